// File: doc/BRIEF.md
# Unaligned Byte Write Packer

This block takes a write request with any start byte address and byte length. It turns the request into a series of 32-bit program operations, each on a word-aligned address, and hands them to a word programmer downstream. The caller supplies the data one byte at a time on a valid/ready stream. Any lane of a word that the caller does not cover is filled with 0xFF, so the flash bits behind it stay erased. The block does not read the old word back and merge it.

Each word is sent on a request/acknowledge handshake. The programmer returns an error flag together with the acknowledge. The running count of committed bytes grows only when a word is acknowledged without error. The first failed word ends the request. A request of zero length finishes at once with success. A request that would run past the end of the device is refused before any byte is taken.

The controller is a four-state machine:
- `ST_IDLE` accepts a request. It moves to `ST_FILL` for a valid non-empty request, and to `ST_DONE` for an empty or out-of-range one.
- `ST_FILL` takes bytes into the current word. It moves to `ST_PROG` when the last byte that belongs to that word is taken.
- `ST_PROG` holds the word out to the programmer. On an acknowledge it moves back to `ST_FILL` if bytes remain, and to `ST_DONE` on an error or when the request is finished.
- `ST_DONE` pulses the completion outputs for one cycle and returns to `ST_IDLE`.

Top module: `byte_write_packer`

## Requirements
- R1: After reset the block is idle: req_ready=1, in_ready=0, pgm_req=0, done=0, committed=0.
- R2: A request with length 0 gives a done pulse with status 0 (success) and committed=0. It takes no bytes and issues no word.
- R3: A request with start+length greater than DEV_BYTES gives a done pulse with status 1 (range). It takes no bytes and issues no word.
- R4: The first word of an unaligned request goes to the start address with its two low bits cleared. Byte lane k is data[8k+7:8k] and holds address offset k. Lanes below the start offset hold 0xFF.
- R5: Words in the middle of a request carry four caller bytes each, at addresses that rise by 4.
- R6: When the request ends inside a word, the last word holds the remaining 1 to 3 caller bytes in its lowest lanes. Its other lanes hold 0xFF.
- R7: A request that starts unaligned and ends in the same word issues exactly one word, padded with 0xFF on both sides.
- R8: committed grows by the number of caller bytes in a word, and only at an acknowledge without error. On success it equals the request length when done pulses.
- R9: An acknowledge with the error flag set ends the request: the next cycle has done=1 with status 2 (failure). committed counts only the earlier words, and no further word is issued.
- R10: in_ready is high only while a word is being filled, never at the same time as pgm_req. Exactly the bytes that belong to issued words are taken.
- R11: While pgm_req is high and not acknowledged, pgm_req, pgm_addr and pgm_data hold steady.
- R12: done lasts one cycle and is followed by req_ready=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken this cycle |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | ADDR_W+1 | Byte count |
| in_valid | input | 1 | Data byte present |
| in_ready | output | 1 | Block takes the byte this cycle |
| in_byte | input | 8 | Data byte |
| pgm_req | output | 1 | Word program request |
| pgm_addr | output | ADDR_W | Aligned word byte address |
| pgm_data | output | 32 | Word to program, lane k = offset k |
| pgm_ack | input | 1 | Programmer finished the word |
| pgm_err | input | 1 | Word failed, valid with pgm_ack |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 success, 1 range refused, 2 program failure |
| committed | output | ADDR_W+1 | Bytes committed so far |

## Verification
The assertions assume that the programmer raises pgm_ack only while pgm_req is high. They also assume that pgm_err has meaning only in the cycle of an acknowledge, and that a request is presented only while req_ready is high. The stimulus respects all three. Acknowledges are driven only in a cycle where pgm_req is seen high and not yet answered. Every acknowledge is dropped in the following cycle, and each request is offered once from the idle state. Byte gaps and acknowledge delays are varied across the sweep, so the hold and pulse properties are exercised under stalls.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2,
        ST_DONE = 2'd3
    } bwp_state_e;

    typedef enum logic [1:0] {
        STAT_OK    = 2'd0,
        STAT_RANGE = 2'd1,
        STAT_FAIL  = 2'd2
    } bwp_status_e;
endpackage

// File: rtl/bwp_lane_span.sv
// Works out how many caller bytes land in the current word and which lane is the last.
module bwp_lane_span #(
    parameter int LEN_W = 7
) (
    input  logic [1:0]       start_lane,
    input  logic [LEN_W-1:0] remaining,
    output logic [2:0]       nbytes,
    output logic [1:0]       last_lane
);
    logic [2:0] room;

    always_comb begin
        room = 3'd4 - {1'b0, start_lane};
        if (remaining < LEN_W'(room))
            nbytes = remaining[2:0];
        else
            nbytes = room;
        last_lane = start_lane + nbytes[1:0] - 2'd1;
    end
endmodule

// File: rtl/bwp_word_buf.sv
// Word assembly register: every lane returns to 0xFF on clear, one lane is written per byte.
module bwp_word_buf #(
    parameter int LANES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [1:0]         wr_lane,
    input  logic [7:0]         wr_byte,
    output logic [8*LANES-1:0] word
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word[8*g +: 8] <= 8'hFF;
            else if (clear)
                word[8*g +: 8] <= 8'hFF;
            else if (wr_en && (wr_lane == 2'(g)))
                word[8*g +: 8] <= wr_byte;
        end
    end
endmodule

// File: rtl/byte_write_packer.sv
module byte_write_packer
    import bwp_pkg::*;
#(
    parameter int ADDR_W    = 6,
    parameter int DEV_BYTES = 64,
    parameter int LEN_W     = ADDR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_byte,
    output logic              pgm_req,
    output logic [ADDR_W-1:0] pgm_addr,
    output logic [31:0]       pgm_data,
    input  logic              pgm_ack,
    input  logic              pgm_err,
    output logic              done,
    output logic [1:0]        status,
    output logic [LEN_W-1:0]  committed
);
    localparam int SUM_W = ADDR_W + 2;

    bwp_state_e        state, state_nx;
    bwp_status_e       stat_q;
    logic [ADDR_W-1:0] word_addr;
    logic [1:0]        start_lane, cur_lane, last_lane;
    logic [LEN_W-1:0]  remaining, commit_q;
    logic [2:0]        nbytes;
    logic [SUM_W-1:0]  end_sum;
    logic              over, accept, take, ack_ok, word_last, buf_clear;

    assign end_sum   = SUM_W'(req_addr) + SUM_W'(req_len);
    assign over      = end_sum > SUM_W'(DEV_BYTES);
    assign accept    = (state == ST_IDLE) && req_valid;
    assign take      = (state == ST_FILL) && in_valid;
    assign ack_ok    = (state == ST_PROG) && pgm_ack && !pgm_err;
    assign word_last = (remaining == LEN_W'(nbytes));
    assign buf_clear = accept || ack_ok;

    bwp_lane_span #(.LEN_W(LEN_W)) u_span (
        .start_lane (start_lane),
        .remaining  (remaining),
        .nbytes     (nbytes),
        .last_lane  (last_lane)
    );

    bwp_word_buf #(.LANES(LANES)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (take),
        .wr_lane (cur_lane),
        .wr_byte (in_byte),
        .word    (pgm_data)
    );

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (req_valid)
                         state_nx = (req_len == '0 || over) ? ST_DONE : ST_FILL;
            ST_FILL: if (in_valid && cur_lane == last_lane)
                         state_nx = ST_PROG;
            ST_PROG: if (pgm_ack)
                         state_nx = (pgm_err || word_last) ? ST_DONE : ST_FILL;
            ST_DONE: state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Request datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr  <= '0;
            start_lane <= '0;
            cur_lane   <= '0;
            remaining  <= '0;
            commit_q   <= '0;
            stat_q     <= STAT_OK;
        end else if (accept) begin
            word_addr  <= {req_addr[ADDR_W-1:2], 2'b00};
            start_lane <= req_addr[1:0];
            cur_lane   <= req_addr[1:0];
            remaining  <= req_len;
            commit_q   <= '0;
            stat_q     <= (req_len != '0 && over) ? STAT_RANGE : STAT_OK;
        end else if (take) begin
            cur_lane   <= cur_lane + 2'd1;
        end else if (ack_ok) begin
            commit_q   <= commit_q + LEN_W'(nbytes);
            remaining  <= remaining - LEN_W'(nbytes);
            word_addr  <= word_addr + ADDR_W'(LANES);
            start_lane <= '0;
            cur_lane   <= '0;
        end else if (state == ST_PROG && pgm_ack) begin
            stat_q     <= STAT_FAIL;
        end
    end

    // Outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        in_ready  = (state == ST_FILL);
        pgm_req   = (state == ST_PROG);
        done      = (state == ST_DONE);
        pgm_addr  = word_addr;
        status    = stat_q;
        committed = commit_q;
    end
endmodule

// File: rtl/bwp_checker.sv
module bwp_checker #(
    parameter int ADDR_W = 6,
    parameter int LEN_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              in_ready,
    input logic              pgm_req,
    input logic [ADDR_W-1:0] pgm_addr,
    input logic [31:0]       pgm_data,
    input logic              pgm_ack,
    input logic              pgm_err,
    input logic              done,
    input logic [1:0]        status,
    input logic [LEN_W-1:0]  committed
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!in_ready && !pgm_req && !done));

    assert_word_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_req |-> (pgm_addr[1:0] == 2'b00));

    assert_commit_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pgm_req && pgm_ack && !pgm_err) && !(req_valid && req_ready)) |=> $stable(committed));

    assert_fail_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && pgm_ack && pgm_err) |=> (done && status == 2'd2));

    assert_fill_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && pgm_req));

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_req && !pgm_ack) |=> (pgm_req && $stable(pgm_addr) && $stable(pgm_data)));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && req_ready));
endmodule

bind byte_write_packer bwp_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .in_ready  (in_ready),
    .pgm_req   (pgm_req),
    .pgm_addr  (pgm_addr),
    .pgm_data  (pgm_data),
    .pgm_ack   (pgm_ack),
    .pgm_err   (pgm_err),
    .done      (done),
    .status    (status),
    .committed (committed)
);

// File: tb/sim_byte_write_packer.sv
`timescale 1ns/1ps
module sim_byte_write_packer;
    localparam int ADDR_W = 6;
    localparam int DEV    = 64;
    localparam int LEN_W  = ADDR_W + 1;
    localparam int NONE   = 99;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_byte = '0;
    logic              pgm_req;
    logic [ADDR_W-1:0] pgm_addr;
    logic [31:0]       pgm_data;
    logic              pgm_ack = 1'b0;
    logic              pgm_err = 1'b0;
    logic              done;
    logic [1:0]        status;
    logic [LEN_W-1:0]  committed;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    byte_write_packer #(.ADDR_W(ADDR_W), .DEV_BYTES(DEV)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_len(req_len), .in_valid(in_valid), .in_ready(in_ready),
        .in_byte(in_byte), .pgm_req(pgm_req), .pgm_addr(pgm_addr), .pgm_data(pgm_data),
        .pgm_ack(pgm_ack), .pgm_err(pgm_err), .done(done), .status(status),
        .committed(committed)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int a, input int l, input int i);
        return 8'(a * 29 + i * 11 + l * 3 + 5);
    endfunction

    function automatic int imin(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

    task automatic run_req(input int a, input int l, input int fw, input bit gap, input bit lat);
        int base, nw, exp_words, exp_cons, exp_comm, exp_stat;
        int widx = 0, cons = 0, extra = 0, wait_cnt = 0;
        bit got_done = 0;
        logic [1:0]       st = '0;
        logic [LEN_W-1:0] cm = '0;
        base = a & ~3;
        nw = (l == 0) ? 0 : ((a + l - 1) >> 2) - (a >> 2) + 1;
        if (l == 0 || a + l > DEV) begin
            exp_words = 0; exp_cons = 0; exp_comm = 0;
            exp_stat = (l == 0) ? 0 : 1;
        end else if (fw < nw) begin
            exp_words = fw + 1;
            exp_cons = imin(base + 4 * (fw + 1), a + l) - a;
            exp_comm = (fw == 0) ? 0 : imin(base + 4 * fw, a + l) - a;
            exp_stat = 2;
        end else begin
            exp_words = nw; exp_cons = l; exp_comm = l; exp_stat = 0;
        end

        @(negedge clk);
        check(req_ready === 1'b1, "R12 ready before request", 64'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(a);
        req_len   = LEN_W'(l);
        @(negedge clk);
        req_valid = 1'b0;
        for (int cyc = 0; cyc < 600; cyc++) begin
            if (done) begin
                got_done = 1;
                st = status;
                cm = committed;
                break;
            end
            if (pgm_req && !pgm_ack) begin
                if (lat && wait_cnt == 0) begin
                    wait_cnt = 1;
                end else begin
                    int wa;
                    logic [31:0] ew;
                    string tg;
                    wa = base + 4 * widx;
                    for (int k = 0; k < 4; k++) begin
                        int pos;
                        pos = wa + k - a;
                        ew[8*k +: 8] = (pos >= 0 && pos < l) ? bval(a, l, pos) : 8'hFF;
                    end
                    if (nw == 1 && (a % 4) != 0 && ((a + l) % 4) != 0) tg = "R7 single padded word";
                    else if (widx == 0 && (a % 4) != 0) tg = "R4 head word";
                    else if (widx == nw - 1 && ((a + l) % 4) != 0) tg = "R6 tail word";
                    else tg = "R5 whole word";
                    check(int'(pgm_addr) == wa, {tg, " address"}, 64'(pgm_addr), 64'(wa));
                    check(pgm_data === ew, {tg, " data"}, 64'(pgm_data), 64'(ew));
                    pgm_ack = 1'b1;
                    pgm_err = (widx == fw);
                    widx++;
                    wait_cnt = 0;
                end
            end else begin
                pgm_ack = 1'b0;
                pgm_err = 1'b0;
            end
            if (in_ready && cons >= l) extra++;
            in_valid = (cons < l) && !(gap && (cyc % 3 == 1));
            in_byte  = bval(a, l, cons);
            if (in_valid && in_ready) cons++;
            @(negedge clk);
        end
        in_valid = 1'b0;
        pgm_ack  = 1'b0;
        pgm_err  = 1'b0;
        check(got_done, "R12 done reached (watchdog)", 64'(got_done), 1);
        check(int'(st) == exp_stat, "R2/R3/R9 status", 64'(st), 64'(exp_stat));
        check(int'(cm) == exp_comm, "R8 committed count", 64'(cm), 64'(exp_comm));
        check(widx == exp_words, "R9 words issued", 64'(widx), 64'(exp_words));
        check(cons == exp_cons && extra == 0, "R10 bytes taken", 64'(cons), 64'(exp_cons));
        @(negedge clk);
        check(!done && req_ready, "R12 one-cycle done then idle", 64'(done), 0);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready && !in_ready && !pgm_req && !done && committed == 0,
              "R1 reset state", {60'b0, req_ready, in_ready, pgm_req, done}, 64'h8);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !in_ready && !pgm_req && !done && committed == 0,
              "R1 idle after reset", {60'b0, req_ready, in_ready, pgm_req, done}, 64'h8);
        // R2, R4..R8, R10: sweep start offsets and lengths
        for (int a = 0; a < 8; a++)
            for (int l = 0; l <= 12; l++)
                run_req(a, l, NONE, ((a + l) % 2) == 1, (l % 3) == 2);
        // R9: failure on each word position
        for (int a = 1; a <= 3; a++)
            for (int f = 0; f < 3; f++)
                run_req(a, 9, f, 1'b0, f == 1);
        run_req(0, 8, 0, 1'b1, 1'b0);
        run_req(4, 12, 2, 1'b0, 1'b1);
        // R3: range edges
        run_req(60, 5, NONE, 1'b0, 1'b0);
        run_req(63, 2, NONE, 1'b1, 1'b0);
        run_req(60, 4, NONE, 1'b0, 1'b0);
        run_req(63, 1, NONE, 1'b0, 1'b1);
        run_req(0, 64, NONE, 1'b1, 1'b1);
        run_req(1, 63, NONE, 1'b0, 1'b0);
        finish_run();
    end
endmodule